// File: doc/BRIEF.md
# Sound Chip Bus Router

This block joins a host that speaks a two-wire sound-generator bus cycle code (`bdir`, `bc1` plus an 8-bit bidirectional data bus) to three sound chips on one shared internal 8-bit bus. Two of the chips are FM/PSG parts that can be read back. The third is a write-only auxiliary chip. The host first latches a register number and then writes or reads data. The block keeps a shadow copy of the register number for each chip. It turns each host data access into a timed sequence on the chip side. That sequence first re-presents the chip's register number and then moves the data, with the select, strobe and A0 levels that chip expects.

Latched numbers at or above a command threshold are configuration commands and never reach a chip. Their low nibble sets which FM chip is addressed, whether reads return status or register contents, and whether the auxiliary chip is in use. Two static mode pins limit which of these options apply. The host cycle code is synchronised into the system clock. All chip-side strobes are derived from registered state. The host bus interface has no back-pressure: the host holds each cycle code long enough for the chip-side sequence to finish, and a read result appears on the host bus while the read code is still held.

Top module: `snd_bus_router`

## Requirements
- R1: The cycle code `{bdir,bc1}` means 2'b11 latch register number, 2'b10 data write, 2'b01 data read, 2'b00 idle; while idle, no chip strobe falls and the host bus is not driven.
- R2: A latched byte of 0xF0 or more loads its bits [3:0] into the configuration register and leaves every chip's shadow register number unchanged.
- R3: After reset the configuration register holds 4'b1111 and every shadow register number holds 0xFF.
- R4: The target is the auxiliary chip when mode is 2'b11 and config bit 3 is 0; otherwise it is FM chip 0 (`fm_cs_n[0]`) when mode is not 2'b00 and config bit 0 is 0; otherwise it is FM chip 1 (`fm_cs_n[1]`). Register numbers below 0xF0 are stored in the target's shadow.
- R5: A data write to an FM chip strobes first its shadow register number with `fm_a0`=0, then the data byte with `fm_a0`=1.
- R6: A data write to the auxiliary chip strobes its shadow register number with `aux_a0`=1, then the data byte with `aux_a0`=0.
- R7: A read whose target is the auxiliary chip drives 0xFF on the host bus and makes no chip access.
- R8: An FM read first re-presents the shadow number (`fm_a0`=0). It then asserts `fm_rd_n` with `fm_a0`=0 (status) when mode bit 1 is 1 and config bits 1 and 2 are both 0, and with `fm_a0`=1 (register contents) otherwise. The byte read is driven onto the host bus.
- R9: The host bus is driven only while the code is 2'b01. The block drives the chip bus only during its own write phases and never while `fm_rd_n` is low.
- R10: Each strobe is paired with exactly one chip select. A0 and the chip-bus byte are unchanged for at least one clock before a write strobe falls and for one clock after it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bdir | input | 1 | Host cycle code, upper bit |
| bc1 | input | 1 | Host cycle code, lower bit |
| mode_sel | input | 2 | Board mode: 00 solo, 01 dual, 10 dual FM, 11 dual FM plus auxiliary |
| host_d | inout | 8 | Host data bus |
| chip_d | inout | 8 | Shared chip data bus |
| fm_cs_n | output | 2 | FM chip selects, bit 0 chip 0, bit 1 chip 1 |
| fm_rd_n | output | 1 | FM read strobe |
| fm_wr_n | output | 1 | FM write strobe |
| fm_a0 | output | 1 | FM address/data select |
| aux_cs_n | output | 1 | Auxiliary chip select |
| aux_wr_n | output | 1 | Auxiliary write strobe |
| aux_a0 | output | 1 | Auxiliary address/data select |

## Verification
A corrupted configuration register sends the next data access to the wrong chip select, or flips the A0 level of the next read. The wrong chip model then shows the byte within one host cycle. A wrong shadow register number is hidden until that chip's next data write or read, because the address is re-presented only then. The chip model's address latch and the returned read byte both expose it. A sequencing fault in the strobe phases shows at once as a select without a strobe, or as A0 or data moving next to a strobe edge.

// File: rtl/snd_router_pkg.sv
package snd_router_pkg;

  typedef enum logic [1:0] {
    TGT_FM0 = 2'd0,
    TGT_FM1 = 2'd1,
    TGT_AUX = 2'd2
  } tgt_e;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'b00,
    CYC_READ  = 2'b01,
    CYC_WRITE = 2'b10,
    CYC_LATCH = 2'b11
  } cyc_e;

  typedef enum logic [1:0] {
    MODE_SOLO   = 2'b00,
    MODE_DUAL   = 2'b01,
    MODE_DUALFM = 2'b10,
    MODE_FULL   = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ASET, PH_ASTB, PH_AHLD,
    PH_DSET, PH_DSTB, PH_DHLD, PH_WAIT
  } phase_e;

  localparam int NUM_SLOTS = 2 ** $bits(tgt_e);

endpackage

// File: rtl/rtr_sync.sv
module rtr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st[i] <= '0;
          else        st[i] <= d;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st[i] <= '0;
          else        st[i] <= st[i-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/rtr_route_dec.sv
module rtr_route_dec
  import snd_router_pkg::*;
#(
  parameter int CFG_W = 4
) (
  input  logic [1:0]       mode,
  input  logic [CFG_W-1:0] cfg,
  output tgt_e             tgt,
  output logic             aux_sel,
  output logic             read_stat
);
  localparam int B_CHIP = 0;
  localparam int B_REGR = 1;
  localparam int B_FMOFF = 2;
  localparam int B_AUXN = 3;

  always_comb begin
    aux_sel = (mode_e'(mode) == MODE_FULL) && !cfg[B_AUXN];
    if (aux_sel)
      tgt = TGT_AUX;
    else if ((mode_e'(mode) != MODE_SOLO) && !cfg[B_CHIP])
      tgt = TGT_FM0;
    else
      tgt = TGT_FM1;
    read_stat = mode[1] && !cfg[B_REGR] && !cfg[B_FMOFF];
  end
endmodule

// File: rtl/rtr_access_seq.sv
module rtr_access_seq
  import snd_router_pkg::*;
#(
  parameter int            DW       = 8,
  parameter int            CFG_W    = 4,
  parameter int            STB_CYC  = 4,
  parameter logic [DW-1:0] CMD_BASE = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       code,
  input  logic [DW-1:0]    hd_in,
  input  tgt_e             tgt,
  input  logic             aux_sel,
  input  logic             read_stat,
  input  logic [DW-1:0]    cb_in,
  output logic [CFG_W-1:0] cfg,
  output logic [DW-1:0]    cb_out,
  output logic             cb_oe,
  output logic [DW-1:0]    rd_buf,
  output logic [1:0]       fm_cs_n,
  output logic             fm_wr_n,
  output logic             fm_rd_n,
  output logic             fm_a0,
  output logic             aux_cs_n,
  output logic             aux_wr_n,
  output logic             aux_a0
);
  localparam int CW = $clog2(STB_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(STB_CYC - 1);

  phase_e        ph;
  tgt_e          cur_tgt;
  logic          is_rd, want_stat;
  logic [CW-1:0] cnt;
  logic [DW-1:0] wdat;
  logic [DW-1:0] shadow [NUM_SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      cur_tgt   <= TGT_FM1;
      is_rd     <= 1'b0;
      want_stat <= 1'b0;
      cnt       <= '0;
      wdat      <= '0;
      cfg       <= '1;
      rd_buf    <= '1;
      for (int i = 0; i < NUM_SLOTS; i++) shadow[i] <= '1;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          unique case (cyc_e'(code))
            CYC_LATCH: begin
              if (hd_in >= CMD_BASE) cfg <= hd_in[CFG_W-1:0];
              else                   shadow[tgt] <= hd_in;
              ph <= PH_WAIT;
            end
            CYC_WRITE: begin
              cur_tgt <= tgt;
              wdat    <= hd_in;
              is_rd   <= 1'b0;
              ph      <= PH_ASET;
            end
            CYC_READ: begin
              if (aux_sel) begin
                rd_buf <= '1;
                ph     <= PH_WAIT;
              end else begin
                cur_tgt   <= tgt;
                is_rd     <= 1'b1;
                want_stat <= read_stat;
                ph        <= PH_ASET;
              end
            end
            default: ph <= PH_IDLE;
          endcase
        end
        PH_ASET: begin cnt <= '0; ph <= PH_ASTB; end
        PH_ASTB: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_LAST) ph <= PH_AHLD;
        end
        PH_AHLD: ph <= PH_DSET;
        PH_DSET: begin cnt <= '0; ph <= PH_DSTB; end
        PH_DSTB: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_LAST) begin
            if (is_rd) rd_buf <= cb_in;
            ph <= PH_DHLD;
          end
        end
        PH_DHLD: ph <= PH_WAIT;
        PH_WAIT: if (cyc_e'(code) == CYC_IDLE) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  logic in_addr, in_data, stb_a, stb_d, stb, to_aux;
  always_comb begin
    in_addr = (ph == PH_ASET) || (ph == PH_ASTB) || (ph == PH_AHLD);
    in_data = (ph == PH_DSET) || (ph == PH_DSTB) || (ph == PH_DHLD);
    stb_a   = (ph == PH_ASTB);
    stb_d   = (ph == PH_DSTB);
    stb     = stb_a || stb_d;
    to_aux  = (cur_tgt == TGT_AUX);

    cb_oe   = in_addr || (in_data && !is_rd);
    cb_out  = in_data ? wdat : shadow[cur_tgt];

    fm_cs_n[0] = !(stb && cur_tgt == TGT_FM0);
    fm_cs_n[1] = !(stb && cur_tgt == TGT_FM1);
    fm_wr_n    = !(stb && !to_aux && !(is_rd && stb_d));
    fm_rd_n    = !(stb_d && is_rd);
    fm_a0      = in_data && !(is_rd && want_stat);

    aux_cs_n   = !(stb && to_aux);
    aux_wr_n   = !(stb && to_aux);
    aux_a0     = !in_data;
  end
endmodule

// File: rtl/snd_bus_router.sv
module snd_bus_router
  import snd_router_pkg::*;
#(
  parameter int            DW          = 8,
  parameter int            CFG_W       = 4,
  parameter int            STB_CYC     = 4,
  parameter int            SYNC_STAGES = 2,
  parameter logic [DW-1:0] CMD_BASE    = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bdir,
  input  logic          bc1,
  input  logic [1:0]    mode_sel,
  inout  wire  [DW-1:0] host_d,
  inout  wire  [DW-1:0] chip_d,
  output logic [1:0]    fm_cs_n,
  output logic          fm_rd_n,
  output logic          fm_wr_n,
  output logic          fm_a0,
  output logic          aux_cs_n,
  output logic          aux_wr_n,
  output logic          aux_a0
);
  logic [1:0]       code_s;
  logic [CFG_W-1:0] cfg;
  tgt_e             tgt;
  logic             aux_sel, read_stat;
  logic [DW-1:0]    cb_out, rd_buf;
  logic             cb_oe, hd_oe;

  rtr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({bdir, bc1}), .q(code_s)
  );

  rtr_route_dec #(.CFG_W(CFG_W)) u_dec (
    .mode(mode_sel), .cfg(cfg), .tgt(tgt),
    .aux_sel(aux_sel), .read_stat(read_stat)
  );

  rtr_access_seq #(
    .DW(DW), .CFG_W(CFG_W), .STB_CYC(STB_CYC), .CMD_BASE(CMD_BASE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .code(code_s), .hd_in(host_d),
    .tgt(tgt), .aux_sel(aux_sel), .read_stat(read_stat),
    .cb_in(chip_d), .cfg(cfg), .cb_out(cb_out), .cb_oe(cb_oe),
    .rd_buf(rd_buf), .fm_cs_n(fm_cs_n), .fm_wr_n(fm_wr_n),
    .fm_rd_n(fm_rd_n), .fm_a0(fm_a0), .aux_cs_n(aux_cs_n),
    .aux_wr_n(aux_wr_n), .aux_a0(aux_a0)
  );

  assign hd_oe  = !bdir && bc1;
  assign host_d = hd_oe ? rd_buf : {DW{1'bz}};
  assign chip_d = cb_oe ? cb_out : {DW{1'bz}};
endmodule

// File: rtl/snd_bus_router_chk.sv
module snd_bus_router_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    fm_cs_n,
  input logic          fm_rd_n,
  input logic          fm_wr_n,
  input logic          fm_a0,
  input logic          aux_cs_n,
  input logic          aux_wr_n,
  input logic          aux_a0,
  input logic          cb_oe,
  input logic [DW-1:0] cb_out
);
  // R10
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~fm_cs_n, ~aux_cs_n}));

  // R10
  fm_strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fm_wr_n || !fm_rd_n) |-> (fm_cs_n != 2'b11));

  // R10
  fm_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fm_wr_n) |-> ($stable(fm_a0) && $stable(cb_out) && $past(cb_oe)));

  // R10
  fm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fm_wr_n) |-> ($stable(fm_a0) && $stable(cb_out) && cb_oe));

  // R6
  aux_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aux_wr_n) |-> ($stable(aux_a0) && $stable(cb_out) && $past(cb_oe)));

  // R6
  aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux_wr_n) |-> ($stable(aux_a0) && $stable(cb_out) && cb_oe));

  // R9
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fm_rd_n |-> !cb_oe);

  // R7
  aux_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_cs_n |-> fm_rd_n);
endmodule

bind snd_bus_router snd_bus_router_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fm_cs_n(fm_cs_n), .fm_rd_n(fm_rd_n),
  .fm_wr_n(fm_wr_n), .fm_a0(fm_a0), .aux_cs_n(aux_cs_n),
  .aux_wr_n(aux_wr_n), .aux_a0(aux_a0), .cb_oe(cb_oe), .cb_out(cb_out)
);

// File: tb/sim_snd_bus_router.sv
`timescale 1ns/1ps
module sim_snd_bus_router;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bdir = 1'b0, bc1 = 1'b0;
  logic [1:0] mode_sel = 2'b11;
  logic h_drv = 1'b0;
  logic [7:0] h_val = 8'h00;
  wire  [7:0] hbus, cbus;
  logic [1:0] fm_cs_n;
  logic fm_rd_n, fm_wr_n, fm_a0, aux_cs_n, aux_wr_n, aux_a0;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  snd_bus_router u0 (
    .clk(clk), .rst_n(rst_n), .bdir(bdir), .bc1(bc1), .mode_sel(mode_sel),
    .host_d(hbus), .chip_d(cbus), .fm_cs_n(fm_cs_n), .fm_rd_n(fm_rd_n),
    .fm_wr_n(fm_wr_n), .fm_a0(fm_a0), .aux_cs_n(aux_cs_n),
    .aux_wr_n(aux_wr_n), .aux_a0(aux_a0)
  );

  assign hbus = h_drv ? h_val : 8'hzz;

  // chip models: FM register read = address ^ 0xA5, status = 0x40 | chip
  logic [7:0] fm_addr [2] = '{8'hFF, 8'hFF};
  logic [7:0] fm_data [2] = '{8'hFF, 8'hFF};
  logic [7:0] aux_addr = 8'hFF, aux_data = 8'hFF;
  int   acc = 0;
  logic fm_wr_q = 1'b1, fm_rd_q = 1'b1, aux_wr_q = 1'b1;

  assign cbus = (!fm_rd_n && !fm_cs_n[0]) ? (fm_a0 ? (fm_addr[0] ^ 8'hA5) : 8'h40) :
                (!fm_rd_n && !fm_cs_n[1]) ? (fm_a0 ? (fm_addr[1] ^ 8'hA5) : 8'h41) :
                8'hzz;

  always @(negedge clk) begin
    if (!fm_wr_n) begin
      for (int i = 0; i < 2; i++)
        if (!fm_cs_n[i]) begin
          if (fm_a0) fm_data[i] <= cbus;
          else       fm_addr[i] <= cbus;
        end
    end
    if (!aux_wr_n && !aux_cs_n) begin
      if (aux_a0) aux_addr <= cbus;
      else        aux_data <= cbus;
    end
    if ((fm_wr_q && !fm_wr_n) || (fm_rd_q && !fm_rd_n) || (aux_wr_q && !aux_wr_n))
      acc <= acc + 1;
    fm_wr_q  <= fm_wr_n;
    fm_rd_q  <= fm_rd_n;
    aux_wr_q <= aux_wr_n;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host(input logic [1:0] cyc, input logic [7:0] din, output logic [7:0] dout);
    @(negedge clk);
    h_drv = (cyc != 2'b01);
    h_val = din;
    repeat (2) @(negedge clk);
    {bdir, bc1} = cyc;
    repeat (40) @(negedge clk);
    dout = hbus;
    {bdir, bc1} = 2'b00;
    repeat (2) @(negedge clk);
    h_drv = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic latch(input logic [7:0] v);
    logic [7:0] d;
    host(2'b11, v, d);
  endtask

  task automatic wr(input logic [7:0] v);
    logic [7:0] d;
    host(2'b10, v, d);
  endtask

  task automatic rd(output logic [7:0] v);
    host(2'b01, 8'h00, v);
  endtask

  task automatic t_reset;
    chk("R1 fm_cs_n idle", {6'd0, fm_cs_n}, 8'h03);
    chk("R1 strobes idle", {5'd0, fm_wr_n, fm_rd_n, aux_wr_n}, 8'h07);
    chk("R9 host bus released", hbus, 8'hzz);
  endtask

  task automatic t_reset_cfg;
    mode_sel = 2'b11;
    latch(8'h21);
    wr(8'h5B);
    chk("R3 R4 fm1 addr", fm_addr[1], 8'h21);
    chk("R5 fm1 data", fm_data[1], 8'h5B);
    chk("R3 fm0 untouched", fm_addr[0], 8'hFF);
    chk("R3 aux untouched", aux_data, 8'hFF);
  endtask

  task automatic t_solo;
    logic [7:0] v;
    mode_sel = 2'b00;
    latch(8'hFE);
    latch(8'h10);
    wr(8'h77);
    chk("R4 solo fm1 addr", fm_addr[1], 8'h10);
    chk("R4 solo fm1 data", fm_data[1], 8'h77);
    rd(v);
    chk("R8 solo read fm1 register", v, 8'hB5);
    chk("R9 host bus released after read", hbus, 8'hzz);
  endtask

  task automatic t_dual;
    logic [7:0] v;
    mode_sel = 2'b01;
    latch(8'h05);
    wr(8'h11);
    chk("R4 dual fm0 addr", fm_addr[0], 8'h05);
    chk("R5 dual fm0 data", fm_data[0], 8'h11);
    latch(8'hFF);
    wr(8'h22);
    chk("R2 fm1 shadow kept", fm_addr[1], 8'h10);
    chk("R5 fm1 data", fm_data[1], 8'h22);
    latch(8'hF0);
    rd(v);
    chk("R8 dual read register", v, 8'hA0);
  endtask

  task automatic t_status;
    logic [7:0] v;
    mode_sel = 2'b10;
    latch(8'hF8); rd(v); chk("R8 fm0 status", v, 8'h40);
    latch(8'hFC); rd(v); chk("R8 fm0 register", v, 8'hA0);
    latch(8'hF9); rd(v); chk("R8 fm1 status", v, 8'h41);
    latch(8'hFB); rd(v); chk("R8 fm1 register", v, 8'hB5);
  endtask

  task automatic t_aux;
    logic [7:0] v;
    int a0c;
    mode_sel = 2'b11;
    latch(8'hF6);
    latch(8'h33);
    wr(8'h44);
    chk("R6 aux addr", aux_addr, 8'h33);
    chk("R6 aux data", aux_data, 8'h44);
    chk("R4 fm0 data untouched", fm_data[0], 8'h11);
    a0c = acc;
    rd(v);
    chk("R7 aux read value", v, 8'hFF);
    chk("R7 aux read no access", 8'(acc - a0c), 8'h00);
    latch(8'hFE);
    rd(v);
    chk("R4 full mode fm0 register", v, 8'hA0);
  endtask

  task automatic t_idle;
    int a0c;
    a0c = acc;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      h_drv = 1'b1;
      h_val = 8'(k * 13);
    end
    h_drv = 1'b0;
    repeat (10) @(negedge clk);
    chk("R1 idle no access", 8'(acc - a0c), 8'h00);
    chk("R1 idle host released", hbus, 8'hzz);
    chk("R1 idle fm1 data kept", fm_data[1], 8'h22);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_reset_cfg;
    t_solo;
    t_dual;
    t_status;
    t_aux;
    t_idle;
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run;
  end
endmodule